// File: doc/BRIEF.md
# Deep Power-Down Sequencer

This block belongs to a mobile DDR SDRAM controller. It takes the memory into its lowest-power state and brings it back out. When an entry request arrives, it first closes every bank that is still open. It then puts the entry command on the bus with clock enable low and keeps clock enable low for as long as the memory stays asleep. While the memory sleeps, its contents decay.

When a wake request arrives, clock enable goes high again. No command is sent at this point. The block then counts out the long start-up pause. After the pause it replays the whole start-up command list, and each command is followed by enough idle cycles to meet its own timing. Only then does it hand the command bus back to the normal scheduler. Through its busy output, the block holds the scheduler off for the whole episode. It also flags that memory contents are no longer valid.

Top module: `dpd_seq`

## Requirements
- R1: After reset the outputs are: clock enable high, the NOP pin pattern on the bus, and busy, enter_ack, exit_ack and data_lost all low.
- R2: Take an enter request made while idle with banks_open low. In the next cycle the bus carries the entry pattern {cs_n,ras_n,cas_n,we_n}=0110 with clock enable low. In that same cycle enter_ack pulses for one cycle and busy goes high.
- R3: Take an enter request made while idle with banks_open high. In the next cycle the bus carries precharge-all, which is pattern 0010 with a10=1. The entry pattern follows exactly T_RP cycles later, with NOP (0111) in the cycles between.
- R4: After the entry cycle, clock enable stays low and the bus carries NOP until an exit request arrives. Clock enable goes high in the cycle after exit_req is seen, and the bus still carries NOP in that cycle.
- R5: The first start-up command appears exactly CLK_MHZ*PAUSE_US cycles after clock enable rises. Every cycle in between carries NOP with clock enable high.
- R6: The start-up replay issues five commands in this order: precharge-all (0010, a10=1), auto-refresh (0001), auto-refresh (0001), mode-register set (0000, ba=00) and extended mode-register set (0000, ba=10). The next command follows precharge-all after T_RP cycles, follows each refresh after T_RFC cycles, and follows the mode-register set after T_MRD cycles. All cycles in between carry NOP.
- R7: exit_ack pulses for one cycle, exactly T_MRD cycles after the extended mode-register set. busy falls in the same cycle, and the block is idle afterwards. Whenever busy is low, clock enable is high and the bus carries NOP.
- R8: data_lost is high from the entry cycle through the exit_ack cycle, and low in all other cycles.
- R9: An exit request made while idle has no effect. An enter request made while the memory is asleep has no effect.
- R10: Unused address pins are driven low. a10 and ba are 0 for every command except where R3 and R6 state other values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request to enter deep power-down |
| banks_open | input | 1 | High when any bank has an open row |
| exit_req | input | 1 | Request to wake the memory |
| enter_ack | output | 1 | One-cycle pulse in the cycle the entry command is issued |
| exit_ack | output | 1 | One-cycle pulse when start-up replay has completed |
| busy | output | 1 | Block owns the command bus; scheduler must hold off |
| data_lost | output | 1 | Memory contents invalid (asleep or re-initialising) |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10 (all-bank select for precharge) |
| ba | output | 2 | Bank address (selects the extended mode register) |

## Verification
The case that is hardest to reach from the ports is the tail of the whole episode. It needs a full pass through precharge, the asleep state, the long pause and all five replay gaps, and only then can the exact cycle of exit_ack and of the data_lost drop be seen. The bench makes that reachable by overriding the pause to one microsecond. It then sweeps both bank states and several asleep durations. In each run it compares every single cycle against a pin-level expectation built from the timing parameters. Requests that should have no effect are injected while the block is idle and while the memory is asleep, so the following cycles show that nothing changed.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
    typedef enum logic [2:0] {
        C_NOP  = 3'd0,
        C_PRE  = 3'd1,
        C_REF  = 3'd2,
        C_MRS  = 3'd3,
        C_EMRS = 3'd4,
        C_BST  = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WRP   = 3'd1,
        S_DOWN  = 3'd2,
        S_PAUSE = 3'd3,
        S_GAP   = 3'd4
    } st_e;

    localparam int N_STEPS = 5;
    localparam int IDX_W   = $clog2(N_STEPS + 1);
endpackage

// File: rtl/dpd_step_table.sv
module dpd_step_table
    import dpd_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_RFC = 5,
    parameter int T_MRD = 2,
    parameter int CNT_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output cmd_e             cmd,
    output logic [CNT_W-1:0] gap
);
    always_comb begin
        case (idx)
            IDX_W'(0): begin cmd = C_PRE;  gap = CNT_W'(T_RP);  end
            IDX_W'(1): begin cmd = C_REF;  gap = CNT_W'(T_RFC); end
            IDX_W'(2): begin cmd = C_REF;  gap = CNT_W'(T_RFC); end
            IDX_W'(3): begin cmd = C_MRS;  gap = CNT_W'(T_MRD); end
            default:   begin cmd = C_EMRS; gap = CNT_W'(T_MRD); end
        endcase
    end

    always_comb begin
        AST_GAP_NONZERO: assert (gap != '0); // R6
    end
endmodule

// File: rtl/dpd_pin_enc.sv
module dpd_pin_enc
    import dpd_pkg::*;
(
    input  cmd_e       cmd,
    output logic       cs_n,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic       a10,
    output logic [1:0] ba
);
    logic [3:0] pins;

    always_comb begin
        a10 = 1'b0;
        ba  = 2'b00;
        case (cmd)
            C_PRE:   begin pins = 4'b0010; a10 = 1'b1; end
            C_REF:   pins = 4'b0001;
            C_MRS:   pins = 4'b0000;
            C_EMRS:  begin pins = 4'b0000; ba = 2'b10; end
            C_BST:   pins = 4'b0110;
            default: pins = 4'b0111;
        endcase
        {cs_n, ras_n, cas_n, we_n} = pins;
    end
endmodule

// File: rtl/dpd_seq.sv
module dpd_seq
    import dpd_pkg::*;
#(
    parameter int CLK_MHZ  = 250,
    parameter int PAUSE_US = 200,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 5,
    parameter int T_MRD    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_req,
    input  logic       banks_open,
    input  logic       exit_req,
    output logic       enter_ack,
    output logic       exit_ack,
    output logic       busy,
    output logic       data_lost,
    output logic       cke,
    output logic       cs_n,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic       a10,
    output logic [1:0] ba
);
    localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
    localparam int MAX_T1    = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int MAX_T2    = (MAX_T1 > T_MRD) ? MAX_T1 : T_MRD;
    localparam int MAX_CNT   = (PAUSE_CYC > MAX_T2) ? PAUSE_CYC : MAX_T2;
    localparam int CNT_W     = $clog2(MAX_CNT + 1);

    typedef struct packed {
        st_e              st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        cmd_e             cmd;
        logic             cke;
        logic             busy;
        logic             eack;
        logic             xack;
        logic             lost;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0] tbl_idx;
    cmd_e             tbl_cmd;
    logic [CNT_W-1:0] tbl_gap;

    assign tbl_idx = (r_q.st == S_PAUSE) ? '0 : r_q.idx + IDX_W'(1);

    dpd_step_table #(
        .T_RP (T_RP),
        .T_RFC(T_RFC),
        .T_MRD(T_MRD),
        .CNT_W(CNT_W)
    ) u_tbl (
        .idx(tbl_idx),
        .cmd(tbl_cmd),
        .gap(tbl_gap)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = C_NOP;
        r_d.eack = 1'b0;
        r_d.xack = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                r_d.lost = 1'b0;
                if (enter_req) begin
                    r_d.busy = 1'b1;
                    if (banks_open) begin
                        r_d.cmd = C_PRE;
                        r_d.cnt = CNT_W'(T_RP - 1);
                        r_d.st  = S_WRP;
                    end else begin
                        r_d.cmd  = C_BST;
                        r_d.cke  = 1'b0;
                        r_d.eack = 1'b1;
                        r_d.lost = 1'b1;
                        r_d.st   = S_DOWN;
                    end
                end
            end
            S_WRP: begin
                if (r_q.cnt == '0) begin
                    r_d.cmd  = C_BST;
                    r_d.cke  = 1'b0;
                    r_d.eack = 1'b1;
                    r_d.lost = 1'b1;
                    r_d.st   = S_DOWN;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            S_DOWN: begin
                if (exit_req) begin
                    r_d.cke = 1'b1;
                    r_d.cnt = CNT_W'(PAUSE_CYC - 1);
                    r_d.st  = S_PAUSE;
                end
            end
            S_PAUSE: begin
                if (r_q.cnt == '0) begin
                    r_d.idx = '0;
                    r_d.cmd = tbl_cmd;
                    r_d.cnt = tbl_gap - CNT_W'(1);
                    r_d.st  = S_GAP;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            S_GAP: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (r_q.idx == IDX_W'(N_STEPS - 1)) begin
                    r_d.xack = 1'b1;
                    r_d.busy = 1'b0;
                    r_d.st   = S_IDLE;
                end else begin
                    r_d.idx = tbl_idx;
                    r_d.cmd = tbl_cmd;
                    r_d.cnt = tbl_gap - CNT_W'(1);
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.cmd  <= C_NOP;
            r_q.cke  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    dpd_pin_enc u_enc (
        .cmd  (r_q.cmd),
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .a10  (a10),
        .ba   (ba)
    );

    assign enter_ack = r_q.eack;
    assign exit_ack  = r_q.xack;
    assign busy      = r_q.busy;
    assign data_lost = r_q.lost;
    assign cke       = r_q.cke;

    AST_ENTRY_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0110) && enter_ack); // R2
    AST_ASLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111)); // R4
    AST_WAKE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111) && busy); // R4
    AST_FREE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cke && ({cs_n, ras_n, cas_n, we_n} == 4'b0111)); // R7
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enter_ack, exit_ack})); // R7
    AST_XACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        exit_ack |=> !exit_ack && !busy); // R7
    AST_LOST_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        exit_ack |-> data_lost); // R8
    AST_LOST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        exit_ack |=> !data_lost); // R8
endmodule

// File: tb/sim_dpd_seq.sv
module sim_dpd_seq;
    localparam int CLK_MHZ  = 250;
    localparam int PAUSE_US = 1;
    localparam int T_RP     = 3;
    localparam int T_RFC    = 5;
    localparam int T_MRD    = 2;
    localparam int P_CYC    = CLK_MHZ * PAUSE_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_req = 1'b0;
    logic banks_open = 1'b0;
    logic exit_req = 1'b0;
    logic enter_ack, exit_ack, busy, data_lost, cke;
    logic cs_n, ras_n, cas_n, we_n, a10;
    logic [1:0] ba;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dpd_seq #(
        .CLK_MHZ (CLK_MHZ),
        .PAUSE_US(PAUSE_US),
        .T_RP    (T_RP),
        .T_RFC   (T_RFC),
        .T_MRD   (T_MRD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .banks_open(banks_open),
        .exit_req(exit_req), .enter_ack(enter_ack), .exit_ack(exit_ack),
        .busy(busy), .data_lost(data_lost), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba)
    );

    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_BST = 4'b0110;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_MRS = 4'b0000;

    function automatic logic [11:0] got();
        return {cs_n, ras_n, cas_n, we_n, a10, ba, cke, busy, enter_ack, exit_ack, data_lost};
    endfunction

    function automatic logic [11:0] ex(logic [3:0] p, logic a, logic [1:0] b,
                                       logic ck, logic bz, logic ea, logic xa, logic lo);
        return {p, a, b, ck, bz, ea, xa, lo};
    endfunction

    task automatic chk(input string r, input logic [11:0] exp);
        logic [11:0] g;
        g = got();
        n_chk++;
        if (g !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t got=%b exp=%b", r, $time, g, exp);
        end
    endtask

    function automatic logic [3:0] step_pins(int s);
        case (s)
            0: return P_PRE;
            1, 2: return P_REF;
            default: return P_MRS;
        endcase
    endfunction

    function automatic int step_gap(int s);
        case (s)
            0: return T_RP;
            1, 2: return T_RFC;
            default: return T_MRD;
        endcase
    endfunction

    task automatic episode(input bit open, input int hold);
        @(negedge clk);
        enter_req  = 1'b1;
        banks_open = open;
        @(negedge clk);
        enter_req = 1'b0;
        if (open) begin
            chk("R3 precharge-all", ex(P_PRE, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
            banks_open = 1'b0;
            for (int i = 0; i < T_RP - 1; i++) begin
                @(negedge clk);
                chk("R3 wait tRP", ex(P_NOP, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
            end
            @(negedge clk);
        end
        chk(open ? "R3 entry after tRP" : "R2 entry", ex(P_BST, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R4 R9 asleep", ex(P_NOP, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
            enter_req = (i == 0);
        end
        enter_req = 1'b0;
        exit_req  = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        chk("R4 wake", ex(P_NOP, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
        for (int i = 0; i < P_CYC - 1; i++) begin
            @(negedge clk);
            chk("R5 pause", ex(P_NOP, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
        end
        for (int s = 0; s < 5; s++) begin
            @(negedge clk);
            chk(s == 0 ? "R5 R6 first step" : "R6 R10 step",
                ex(step_pins(s), s == 0, (s == 4) ? 2'b10 : 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
            for (int g = 0; g < step_gap(s) - 1; g++) begin
                @(negedge clk);
                chk("R6 gap", ex(P_NOP, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
            end
        end
        @(negedge clk);
        chk("R7 R8 exit ack", ex(P_NOP, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
        @(negedge clk);
        chk("R7 R8 idle after", ex(P_NOP, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", ex(P_NOP, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        chk("R9 idle exit ignored", ex(P_NOP, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        chk("R9 idle exit ignored", ex(P_NOP, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        for (int o = 0; o < 2; o++) begin
            for (int h = 1; h <= 8; h += 3) begin
                episode(o[0], h);
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule